// File: doc/BRIEF.md
# Reconfigurable-Precision Wallace Multiplier

This block is an unsigned multiplier with an 8-bit by 8-bit datapath and a 16-bit product. A two-bit precision select picks 2x2, 4x4 or 8x8 operation. Each precision has its own datapath level. Every level forms all of its partial-product bits at once with AND gates. It then compresses them with a tree of 3:2 carry-save counters until one sum row and one carry row remain. A carry look-ahead adder adds those two rows.

The operand inputs of the two levels that are not selected are tied to zero, so their internal nodes stay still. This stands in for switching those levels off.

The widest level does not use one large array. It builds four 4x4 sub-products side by side and keeps each one in carry-save form. It then shifts the eight resulting rows into place and merges them with a second carry-save tree before the single final addition.

An operation is started by pulsing the valid input. The product appears in a register on the next cycle, and the valid output is raised in the same cycle.

Top module: `prec_wallace_mul`

## Requirements
- R1: With precision code 2'b10 and in_valid high, product equals op_a*op_b (all 16 bits) on the cycle after, with out_valid high.
- R2: With precision code 2'b01, product equals op_a[3:0]*op_b[3:0], with product[15:8] zero; operand bits 7:4 have no effect on the result.
- R3: With precision code 2'b00, product equals op_a[1:0]*op_b[1:0], with product[15:4] zero; operand bits 7:2 have no effect on the result.
- R4: Precision code 2'b11 is reserved and yields a product of zero.
- R5: out_valid is high exactly in the cycles that follow a cycle with in_valid high.
- R6: While in_valid is low, product keeps its last value whatever the operands and precision code do.
- R7: While rst_n is low (asynchronous, active low), out_valid and product are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Starts one multiply in this cycle |
| op_a | input | 8 | Multiplicand |
| op_b | input | 8 | Multiplier |
| prec | input | 2 | Precision: 00 = 2x2, 01 = 4x4, 10 = 8x8, 11 = reserved |
| out_valid | output | 1 | Product register holds a new result |
| product | output | 16 | Registered unsigned product |

## Verification
The 2x2 and 4x4 precisions are swept over every operand pair, with random junk placed in the unused upper operand bits. Any leak of those bits through the gating shows up as a wrong or over-wide product. The full-width precision gets the corner values 0, 1 and 255 in every pairing, plus a seeded random set. All-ones operands exercise the longest carry chains through both carry-save trees and across every look-ahead group. Idle cycles with the operands changing tell a correct hold apart from a register that loads every cycle, and reserved-code operations with non-zero operands confirm that the output is forced to zero.

// File: rtl/prec_wallace_mul.sv
module prec_wallace_mul #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [1:0]    prec,
  output logic          out_valid,
  output logic [PW-1:0] product
);

  function automatic logic [2*PW-1:0] csa_reduce(input logic [PW-1:0] rows [8], input int n);
    logic [PW-1:0] r [8];
    logic [PW-1:0] t [8];
    int cnt, m;
    r = rows;
    cnt = n;
    for (int st = 0; st < 4; st++) begin
      for (int k = 0; k < 8; k++) t[k] = '0;
      m = 0;
      for (int i = 0; i < 8; i += 3) begin
        if (i + 2 < cnt) begin
          t[m]   = r[i] ^ r[i+1] ^ r[i+2];
          t[m+1] = ((r[i] & r[i+1]) | (r[i] & r[i+2]) | (r[i+1] & r[i+2])) << 1;
          m += 2;
        end else begin
          for (int j = i; j < cnt; j++) begin
            t[m] = r[j];
            m++;
          end
        end
      end
      r = t;
      cnt = m;
    end
    return {r[1], r[0]};
  endfunction

  function automatic logic [PW-1:0] cla(input logic [PW-1:0] x, input logic [PW-1:0] y);
    logic [PW-1:0] g, p, c;
    logic [3:0] gg, gp, gc;
    int b;
    g = x & y;
    p = x ^ y;
    for (int k = 0; k < 4; k++) begin
      b = 4 * k;
      gg[k] = g[b+3] | (p[b+3] & g[b+2]) | (p[b+3] & p[b+2] & g[b+1])
            | (p[b+3] & p[b+2] & p[b+1] & g[b]);
      gp[k] = &p[b +: 4];
    end
    gc[0] = 1'b0;
    gc[1] = gg[0];
    gc[2] = gg[1] | (gp[1] & gg[0]);
    gc[3] = gg[2] | (gp[2] & gg[1]) | (gp[2] & gp[1] & gg[0]);
    for (int k = 0; k < 4; k++) begin
      b = 4 * k;
      c[b]   = gc[k];
      c[b+1] = g[b] | (p[b] & gc[k]);
      c[b+2] = g[b+1] | (p[b+1] & g[b]) | (p[b+1] & p[b] & gc[k]);
      c[b+3] = g[b+2] | (p[b+2] & g[b+1]) | (p[b+2] & p[b+1] & g[b])
             | (p[b+2] & p[b+1] & p[b] & gc[k]);
    end
    return p ^ c;
  endfunction

  logic sel2, sel4, sel8;
  logic [1:0] a2, b2;
  logic [3:0] a4, b4;
  logic [W-1:0] a8, b8;

  assign sel2 = (prec == 2'b00);
  assign sel4 = (prec == 2'b01);
  assign sel8 = (prec == 2'b10);

  assign a2 = sel2 ? op_a[1:0] : '0;
  assign b2 = sel2 ? op_b[1:0] : '0;
  assign a4 = sel4 ? op_a[3:0] : '0;
  assign b4 = sel4 ? op_b[3:0] : '0;
  assign a8 = sel8 ? op_a : '0;
  assign b8 = sel8 ? op_b : '0;

  logic [PW-1:0] res2, res4, res8;

  always_comb begin
    logic [PW-1:0] rows [8];
    logic [2*PW-1:0] sc;
    for (int i = 0; i < 8; i++) rows[i] = '0;
    for (int i = 0; i < 2; i++) rows[i] = PW'(a2 & {2{b2[i]}}) << i;
    sc = csa_reduce(rows, 2);
    res2 = cla(sc[PW-1:0], sc[2*PW-1:PW]);
  end

  always_comb begin
    logic [PW-1:0] rows [8];
    logic [2*PW-1:0] sc;
    for (int i = 0; i < 8; i++) rows[i] = '0;
    for (int i = 0; i < 4; i++) rows[i] = PW'(a4 & {4{b4[i]}}) << i;
    sc = csa_reduce(rows, 4);
    res4 = cla(sc[PW-1:0], sc[2*PW-1:PW]);
  end

  always_comb begin
    logic [PW-1:0] sub [8];
    logic [PW-1:0] top [8];
    logic [2*PW-1:0] sc;
    logic [3:0] sa, sb;
    for (int s = 0; s < 4; s++) begin
      sa = a8[4*(s%2) +: 4];
      sb = b8[4*(s/2) +: 4];
      for (int i = 0; i < 8; i++) sub[i] = '0;
      for (int i = 0; i < 4; i++) sub[i] = PW'(sa & {4{sb[i]}}) << i;
      sc = csa_reduce(sub, 4);
      top[2*s]   = sc[PW-1:0] << (4 * (s % 2 + s / 2));
      top[2*s+1] = sc[2*PW-1:PW] << (4 * (s % 2 + s / 2));
    end
    sc = csa_reduce(top, 8);
    res8 = cla(sc[PW-1:0], sc[2*PW-1:PW]);
  end

  logic [PW-1:0] result;
  always_comb begin
    unique case (prec)
      2'b00:   result = res2;
      2'b01:   result = res4;
      2'b10:   result = res8;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= result;
    end
  end

endmodule

module prec_wallace_mul_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  op_a,
  input logic [7:0]  op_b,
  input logic [1:0]  prec,
  input logic        out_valid,
  input logic [15:0] product
);

  a_r1_full_width: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec == 2'b10) |=> (product == 16'($past(op_a)) * 16'($past(op_b))));

  a_r2_quad_width: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec == 2'b01) |=> (product == 16'($past(op_a[3:0])) * 16'($past(op_b[3:0]))));

  a_r3_pair_width: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec == 2'b00) |=> (product == 16'($past(op_a[1:0])) * 16'($past(op_b[1:0]))));

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec == 2'b11) |=> (product == 16'd0));

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r5_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

  a_r7_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && product == 16'd0));

endmodule

bind prec_wallace_mul prec_wallace_mul_chk u_chk (.*);

// File: tb/prec_wallace_mul_test.sv
module prec_wallace_mul_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [1:0] prec = '0;
  logic out_valid;
  logic [15:0] product;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prec_wallace_mul uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .prec(prec), .out_valid(out_valid), .product(product)
  );

  function automatic logic [15:0] expect_prod(input logic [1:0] m, input logic [7:0] a, input logic [7:0] b);
    case (m)
      2'b00:   return 16'(a & 8'h03) * 16'(b & 8'h03);
      2'b01:   return 16'(a & 8'h0f) * 16'(b & 8'h0f);
      2'b10:   return 16'(a) * 16'(b);
      default: return 16'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R2";
      2'b10:   return "R1";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input logic [7:0] a, input logic [7:0] b, input bit hold);
    logic [15:0] e;
    e = expect_prod(m, a, b);
    @(negedge clk);
    in_valid = 1'b1; prec = m; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5", 32'(out_valid), 32'd1);
    check(req_of(m), 32'(product), 32'(e));
    if (hold) begin
      op_a = 8'($urandom); op_b = 8'($urandom); prec = 2'($urandom);
      @(negedge clk);
      check("R5", 32'(out_valid), 32'd0);
      check("R6", 32'(product), 32'(e));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] corners [3];
    void'($urandom(32'd20251));
    corners[0] = 8'd0; corners[1] = 8'd1; corners[2] = 8'd255;
    repeat (3) @(negedge clk);
    check("R7", 32'(out_valid), 32'd0);
    check("R7", 32'(product), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        run_op(2'b00, {6'($urandom), 2'(i)}, {6'($urandom), 2'(j)}, (i == j));

    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run_op(2'b01, {4'($urandom), 4'(i)}, {4'($urandom), 4'(j)}, (j == 0));

    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        run_op(2'b10, corners[i], corners[j], 1'b1);
    repeat (300) run_op(2'b10, 8'($urandom), 8'($urandom), ($urandom % 4 == 0));

    run_op(2'b11, 8'hff, 8'hff, 1'b1);
    repeat (8) run_op(2'b11, 8'($urandom) | 8'h01, 8'($urandom) | 8'h01, 1'b0);

    run_op(2'b10, 8'd200, 8'd150, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7", 32'(out_valid), 32'd0);
    check("R7", 32'(product), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule